// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block sets the timing of the serial clock for an I2C master. From the system clock and a small set of configuration inputs it drives SCL as an open-drain output: a low phase, then a release, then a high phase. A bit engine beside it uses two one-cycle strobes from the generator. The change strobe marks the start of each low phase, where SDA may be altered. The sample strobe marks the middle of each high phase, where SDA is read.

The phase lengths come from a 12-bit divider, called the unit below. Three duty modes are available. In standard mode the two phases are equal. The fast modes give a 2:1 ratio or a 16:9 ratio. Each mode has its own lower limit on the unit.

When SCL is released, a rise-time count and the sampled SCL line both have to allow it before the high phase begins. As a result, a slave that holds SCL low stretches the bus for as long as it keeps holding it.

The configuration is captured only while the generator is disabled. An input clock rate, given in whole MHz, that falls outside the allowed range is reported and keeps the generator idle.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and from the cycle after `enable` is seen low, `sclOut` is 1 (released), both strobes are 0 and the phase counter is cleared; on the first enabled cycle the low phase begins at count 0.
- R2: With `fastMode`=0 (standard), the unit D is `divider` raised to at least 4. The low phase lasts D cycles and the high phase lasts D cycles.
- R3: With `fastMode`=1 and `dutySel`=0, D is `divider` raised to at least 1. The low phase lasts 2·D cycles and the high phase lasts D cycles.
- R4: With `fastMode`=1 and `dutySel`=1, D is `divider` raised to at least 1. The low phase lasts 16·D cycles and the high phase lasts 9·D cycles.
- R5: In standard mode `dutySel` has no effect on the timing.
- R6: Each released interval of `sclOut` lasts (high phase) + max(2, `riseCount`+1) cycles when `sclIn` follows `sclOut`. The extra cycles are the rise wait plus one cycle for sampling the line.
- R7: While `sclIn` is held low after release, the generator stays in its rise wait and pulses no strobe. Once the line goes high, `sclOut` stays released for (high phase)+1 more cycles.
- R8: `changeTick` is high for exactly one cycle: the first cycle of each low phase.
- R9: `sampleTick` is high for exactly one cycle per released interval, at index max(2, `riseCount`+1) + floor(H/2) counted from the first released cycle (index 0), where H is the high-phase length.
- R10: `cfgError` is 1 whenever the captured `clkMhz` is below 2 or above 36. While it is 1, `enable` does not start the generator, and `sclOut` stays 1 with no strobes.
- R11: The configuration inputs (`divider`, `fastMode`, `dutySel`, `riseCount`, `clkMhz`) are captured only while `enable` is 0. Changes made while enabled have no effect until the generator has been disabled and enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the generator; the configuration is captured while low |
| divider | input | 12 | Phase unit in system clock cycles |
| fastMode | input | 1 | 1 = fast mode, 0 = standard mode |
| dutySel | input | 1 | In fast mode: 1 = 16:9 duty, 0 = 2:1 duty |
| riseCount | input | 6 | Minimum cycles from release to the start of the high phase |
| clkMhz | input | 6 | System clock rate in whole MHz, checked against 2..36 |
| sclIn | input | 1 | Sampled SCL line level |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |
| changeTick | output | 1 | One-cycle strobe at the start of each low phase |
| sampleTick | output | 1 | One-cycle strobe at the middle of each high phase |
| cfgError | output | 1 | The captured clock rate is out of range |

## Verification
The bench goes after the unit clamps and confirms that a divider of 0 or 2 is raised to the mode minimum. A missing clamp would give a zero-length or too-short phase. It also holds SCL low after release. A generator that counted the high phase from its own release, rather than from the sampled line, would pulse `sampleTick` while the line was still held. The bench changes the configuration while the generator runs and expects the old timing to persist. It also tests the clock-rate limits 1, 2, 36 and 37; an off-by-one check would start the generator at a rate it should reject, or reject a rate at the edge of the range.

// File: rtl/scl_timing_pkg.sv
`timescale 1ns/1ps
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } ctlStrobe_t;

endpackage

// File: rtl/scl_timing_datapath.sv
`timescale 1ns/1ps
module scl_timing_datapath
  import scl_timing_pkg::*;
#(
  parameter int DIV_W        = 12,
  parameter int RISE_W       = 6,
  parameter int MHZ_W        = 6,
  parameter int MHZ_MIN      = 2,
  parameter int MHZ_MAX      = 36,
  parameter int STD_MIN_DIV  = 4,
  parameter int FAST_MIN_DIV = 1,
  parameter int CNT_W        = DIV_W + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divIn,
  input  logic              fastIn,
  input  logic              dutyIn,
  input  logic [RISE_W-1:0] riseIn,
  input  logic [MHZ_W-1:0]  mhzIn,
  input  logic              sclIn,
  input  ctlStrobe_t        strobe,
  output logic              lowLast,
  output logic              riseMet,
  output logic              highLast,
  output logic              highMid,
  output logic              cntZero,
  output logic              lineHigh,
  output logic              cfgBad
);

  localparam logic [DIV_W-1:0] STD_MIN  = DIV_W'(STD_MIN_DIV);
  localparam logic [DIV_W-1:0] FAST_MIN = DIV_W'(FAST_MIN_DIV);
  localparam logic [MHZ_W-1:0] MHZ_LO   = MHZ_W'(MHZ_MIN);
  localparam logic [MHZ_W-1:0] MHZ_HI   = MHZ_W'(MHZ_MAX);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  // Shadow copy of the configuration; it follows the inputs only while idle.
  logic [DIV_W-1:0]  divLat;
  logic              fastLat;
  logic              dutyLat;
  logic [RISE_W-1:0] riseLat;
  logic [MHZ_W-1:0]  mhzLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLat  <= STD_MIN;
      fastLat <= 1'b0;
      dutyLat <= 1'b0;
      riseLat <= '0;
      mhzLat  <= MHZ_LO;
    end else if (!enable) begin
      divLat  <= divIn;
      fastLat <= fastIn;
      dutyLat <= dutyIn;
      riseLat <= riseIn;
      mhzLat  <= mhzIn;
    end
  end

  // Clamped unit and phase lengths.
  logic [DIV_W-1:0] unitDiv;
  logic [CNT_W-1:0] unitW;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] highLen;

  always_comb begin
    if (fastLat) unitDiv = (divLat < FAST_MIN) ? FAST_MIN : divLat;
    else         unitDiv = (divLat < STD_MIN)  ? STD_MIN  : divLat;
    unitW = CNT_W'(unitDiv);
    case ({fastLat, dutyLat})
      2'b10: begin
        lowLen  = unitW << 1;
        highLen = unitW;
      end
      2'b11: begin
        lowLen  = unitW << 4;
        highLen = (unitW << 3) + unitW;
      end
      default: begin
        lowLen  = unitW;
        highLen = unitW;
      end
    endcase
  end

  // Phase counter, driven by the control strobes.
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntInc)   cnt <= cnt + ONE;
  end

  // Registered sample of the bus clock line.
  always_ff @(posedge clk) begin
    if (!rstN) lineHigh <= 1'b0;
    else       lineHigh <= sclIn;
  end

  assign lowLast  = (cnt == lowLen - ONE);
  assign highLast = (cnt == highLen - ONE);
  assign highMid  = (cnt == (highLen >> 1));
  assign riseMet  = (cnt == CNT_W'(riseLat));
  assign cntZero  = (cnt == '0);
  assign cfgBad   = (mhzLat < MHZ_LO) || (mhzLat > MHZ_HI);

endmodule

// File: rtl/scl_timing_control.sv
`timescale 1ns/1ps
module scl_timing_control
  import scl_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       lowLast,
  input  logic       riseMet,
  input  logic       highLast,
  input  logic       highMid,
  input  logic       cntZero,
  input  logic       lineHigh,
  input  logic       cfgBad,
  output ctlStrobe_t strobe,
  output logic       sclOut,
  output logic       changeTick,
  output logic       sampleTick
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext       = phase;
    strobe.cntClear = 1'b0;
    strobe.cntInc   = 1'b0;
    case (phase)
      PH_IDLE: begin
        strobe.cntClear = 1'b1;
        if (enable && !cfgBad) phaseNext = PH_LOW;
      end
      PH_LOW: begin
        if (!enable) begin
          phaseNext       = PH_IDLE;
          strobe.cntClear = 1'b1;
        end else if (lowLast) begin
          phaseNext       = PH_RISE;
          strobe.cntClear = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PH_RISE: begin
        if (!enable) begin
          phaseNext       = PH_IDLE;
          strobe.cntClear = 1'b1;
        end else if (riseMet && lineHigh) begin
          phaseNext       = PH_HIGH;
          strobe.cntClear = 1'b1;
        end else begin
          strobe.cntInc = !riseMet;
        end
      end
      PH_HIGH: begin
        if (!enable) begin
          phaseNext       = PH_IDLE;
          strobe.cntClear = 1'b1;
        end else if (highLast) begin
          phaseNext       = PH_LOW;
          strobe.cntClear = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: begin
        phaseNext       = PH_IDLE;
        strobe.cntClear = 1'b1;
      end
    endcase
  end

  assign sclOut     = (phase != PH_LOW);
  assign changeTick = (phase == PH_LOW) && cntZero;
  assign sampleTick = (phase == PH_HIGH) && highMid;

endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int DIV_W        = 12,
  parameter int RISE_W       = 6,
  parameter int MHZ_W        = 6,
  parameter int MHZ_MIN      = 2,
  parameter int MHZ_MAX      = 36,
  parameter int STD_MIN_DIV  = 4,
  parameter int FAST_MIN_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divider,
  input  logic              fastMode,
  input  logic              dutySel,
  input  logic [RISE_W-1:0] riseCount,
  input  logic [MHZ_W-1:0]  clkMhz,
  input  logic              sclIn,
  output logic              sclOut,
  output logic              changeTick,
  output logic              sampleTick,
  output logic              cfgError
);

  localparam int CNT_W = DIV_W + 5;

  ctlStrobe_t strobe;
  logic lowLast, riseMet, highLast, highMid, cntZero, lineHigh, cfgBad;

  scl_timing_datapath #(
    .DIV_W(DIV_W), .RISE_W(RISE_W), .MHZ_W(MHZ_W),
    .MHZ_MIN(MHZ_MIN), .MHZ_MAX(MHZ_MAX),
    .STD_MIN_DIV(STD_MIN_DIV), .FAST_MIN_DIV(FAST_MIN_DIV),
    .CNT_W(CNT_W)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .divIn(divider), .fastIn(fastMode), .dutyIn(dutySel),
    .riseIn(riseCount), .mhzIn(clkMhz), .sclIn(sclIn),
    .strobe(strobe),
    .lowLast(lowLast), .riseMet(riseMet), .highLast(highLast),
    .highMid(highMid), .cntZero(cntZero), .lineHigh(lineHigh),
    .cfgBad(cfgBad)
  );

  scl_timing_control control_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .lowLast(lowLast), .riseMet(riseMet), .highLast(highLast),
    .highMid(highMid), .cntZero(cntZero), .lineHigh(lineHigh),
    .cfgBad(cfgBad),
    .strobe(strobe),
    .sclOut(sclOut), .changeTick(changeTick), .sampleTick(sampleTick)
  );

  assign cfgError = cfgBad;

endmodule

// File: rtl/scl_timing_checker.sv
`timescale 1ns/1ps
module scl_timing_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclIn,
  input logic sclOut,
  input logic changeTick,
  input logic sampleTick,
  input logic cfgError
);

  a_r1_disable_release: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !changeTick && !sampleTick));

  a_r8_change_in_low: assert property (@(posedge clk) disable iff (!rstN)
    changeTick |-> !sclOut);

  a_r8_change_single: assert property (@(posedge clk) disable iff (!rstN)
    changeTick |=> !changeTick);

  a_r9_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> sclOut);

  a_r9_sample_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> !sampleTick);

  a_r7_sample_line_high: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> $past(sclIn));

  a_r10_cfg_idle: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (sclOut && !changeTick && !sampleTick));

endmodule

bind scl_timing_gen scl_timing_checker chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclIn),
  .sclOut(sclOut), .changeTick(changeTick), .sampleTick(sampleTick),
  .cfgError(cfgError)
);

// File: tb/scl_timing_gen_tb_top.sv
`timescale 1ns/1ps
module scl_timing_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [11:0] divider = 12'd10;
  logic        fastMode = 1'b0;
  logic        dutySel = 1'b0;
  logic [5:0]  riseCount = 6'd0;
  logic [5:0]  clkMhz = 6'd8;
  logic        stretchHold = 1'b0;
  logic        sclIn;
  logic        sclOut, changeTick, sampleTick, cfgError;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sclIn = sclOut & ~stretchHold;

  scl_timing_gen dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .divider(divider),
    .fastMode(fastMode), .dutySel(dutySel), .riseCount(riseCount),
    .clkMhz(clkMhz), .sclIn(sclIn), .sclOut(sclOut),
    .changeTick(changeTick), .sampleTick(sampleTick), .cfgError(cfgError)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void expectTiming(input int div, input bit fast, input bit duty,
                                       input int rise, output int lowE,
                                       output int highE, output int idxE);
    int d, h, w;
    d = fast ? ((div < 1) ? 1 : div) : ((div < 4) ? 4 : div);
    if (!fast)     begin lowE = d;      h = d;     end
    else if (duty) begin lowE = 16 * d; h = 9 * d; end
    else           begin lowE = 2 * d;  h = d;     end
    w = (rise + 1 > 2) ? rise + 1 : 2;
    highE = h + w;
    idxE = w + h / 2;
  endfunction

  task automatic setCfg(input int div, input bit fast, input bit duty, input int rise);
    @(negedge clk);
    enable = 1'b0;
    divider = 12'(div);
    fastMode = fast;
    dutySel = duty;
    riseCount = 6'(rise);
    repeat (2) @(negedge clk);
  endtask

  // Measure one full SCL period starting at a change strobe.
  task automatic measure(output int lowC, output int highC, output int sIdx,
                         output int sCnt, output int cCnt, output int nextChg);
    int g;
    g = 0;
    while (!changeTick && g < 5000) begin @(negedge clk); g++; end
    lowC = 0; cCnt = 0; highC = 0; sIdx = -1; sCnt = 0;
    while (!sclOut && g < 5000) begin
      lowC++;
      if (changeTick) cCnt++;
      @(negedge clk); g++;
    end
    while (sclOut && g < 5000) begin
      if (sampleTick) begin sCnt++; sIdx = highC; end
      highC++;
      @(negedge clk); g++;
    end
    nextChg = int'(changeTick);
  endtask

  task automatic runTiming(input string req, input int div, input bit fast,
                           input bit duty, input int rise);
    int lowE, highE, idxE, lowC, highC, sIdx, sCnt, cCnt, nx;
    expectTiming(div, fast, duty, rise, lowE, highE, idxE);
    setCfg(div, fast, duty, rise);
    enable = 1'b1;
    measure(lowC, highC, sIdx, sCnt, cCnt, nx);
    chk(req, "low phase cycles", lowC, lowE);
    chk("R6", "released cycles", highC, highE);
    chk("R8", "change strobes per low phase", cCnt, 1);
    chk("R9", "sample strobe index", sIdx, idxE);
    chk("R9", "sample strobes per high phase", sCnt, 1);
    chk("R8", "change strobe at next low", nx, 1);
    enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "reset sclOut", int'(sclOut), 1);
    chk("R1", "reset changeTick", int'(changeTick), 0);
    chk("R1", "reset sampleTick", int'(sampleTick), 0);
    chk("R1", "reset cfgError", int'(cfgError), 0);
  endtask

  task automatic testStretch();
    int bad, ticks, c, t, g;
    setCfg(6, 1'b0, 1'b0, 0);
    stretchHold = 1'b1;
    enable = 1'b1;
    g = 0;
    while (!sclOut || !changeTick) begin
      @(negedge clk); g++;
      if (changeTick) break;
      if (g > 200) break;
    end
    while (!sclOut && g < 400) begin @(negedge clk); g++; end
    bad = 0; ticks = 0;
    repeat (30) begin
      if (!sclOut || changeTick) bad++;
      if (sampleTick) ticks++;
      @(negedge clk);
    end
    chk("R7", "held line: sclOut low or change strobe seen", bad, 0);
    chk("R7", "held line: sample strobes", ticks, 0);
    stretchHold = 1'b0;
    c = 0; t = 0;
    @(negedge clk);
    while (sclOut && c < 500) begin
      if (sampleTick) t++;
      c++;
      @(negedge clk);
    end
    chk("R7", "released cycles after line high", c, 6 + 1);
    chk("R7", "sample strobes after line high", t, 1);
    enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testDisable();
    int bad, g;
    setCfg(20, 1'b0, 1'b0, 0);
    enable = 1'b1;
    g = 0;
    while (!changeTick && g < 100) begin @(negedge clk); g++; end
    repeat (5) @(negedge clk);
    chk("R1", "still low before disable", int'(sclOut), 0);
    enable = 1'b0;
    @(negedge clk);
    chk("R1", "released after disable", int'(sclOut), 1);
    bad = 0;
    repeat (40) begin
      if (!sclOut || changeTick || sampleTick) bad++;
      @(negedge clk);
    end
    chk("R1", "activity while disabled", bad, 0);
  endtask

  task automatic testFrozen();
    int lowC, highC, sIdx, sCnt, cCnt, nx;
    setCfg(10, 1'b0, 1'b0, 0);
    enable = 1'b1;
    @(negedge clk);
    divider = 12'd20;
    fastMode = 1'b1;
    measure(lowC, highC, sIdx, sCnt, cCnt, nx);
    chk("R11", "low cycles after change while enabled", lowC, 10);
    chk("R11", "released cycles after change while enabled", highC, 12);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    measure(lowC, highC, sIdx, sCnt, cCnt, nx);
    chk("R11", "low cycles after re-enable", lowC, 40);
    chk("R11", "released cycles after re-enable", highC, 22);
    enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testCfg();
    int bad;
    setCfg(10, 1'b0, 1'b0, 0);
    clkMhz = 6'd1;
    @(negedge clk);
    chk("R10", "cfgError at 1 MHz", int'(cfgError), 1);
    enable = 1'b1;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!sclOut || changeTick || sampleTick) bad++;
    end
    chk("R10", "activity with bad clock rate", bad, 0);
    enable = 1'b0;
    clkMhz = 6'd37;
    repeat (2) @(negedge clk);
    chk("R10", "cfgError at 37 MHz", int'(cfgError), 1);
    clkMhz = 6'd36;
    @(negedge clk);
    chk("R10", "cfgError at 36 MHz", int'(cfgError), 0);
    clkMhz = 6'd2;
    @(negedge clk);
    chk("R10", "cfgError at 2 MHz", int'(cfgError), 0);
    clkMhz = 6'd8;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    runTiming("R2", 10, 1'b0, 1'b0, 0);
    runTiming("R2", 2, 1'b0, 1'b0, 0);
    runTiming("R3", 3, 1'b1, 1'b0, 4);
    runTiming("R3", 0, 1'b1, 1'b0, 0);
    runTiming("R4", 2, 1'b1, 1'b1, 0);
    runTiming("R4", 0, 1'b1, 1'b1, 3);
    runTiming("R5", 5, 1'b0, 1'b1, 0);
    runTiming("R6", 4, 1'b0, 1'b0, 7);
    testStretch();
    testDisable();
    testFrozen();
    testCfg();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule